// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits between the interrupt sources of a small 16-bit controller and its CPU. It holds up to 32 priority slots. Each slot maps to one word-aligned vector in the top 64 bytes of the address space. The vector address is `0xFFC0 + 2*slot`, and slot 31 at `0xFFFE` ranks highest. On each cycle with no open request, the block looks at the set of pending requests that are enabled and allowed, and picks the highest slot. It latches that slot and raises a request to the CPU. The selected vector address stays on its output until the CPU acknowledges it.

Slot 31 is the reset slot. Several causes set it: power-up (the block's own reset), five external reset causes, and an instruction fetch from an address that may not hold code. The reset slot ignores every enable. Slot 30 is exempt from the global enable, but its individual enable still applies. All other slots need both their own enable and the global enable.

Single-source slots are one-cycle event pulses that the block latches, and acknowledging the slot clears the latch. Shared slots are level inputs held by their peripherals, and acknowledging them clears nothing in the block. When the CPU acknowledges the reset vector, it also returns the word it fetched from that vector. If that word is `0xFFFF`, the block raises a deep-sleep indication, which stays up until the next reset cause.

Top module: `ivc_vector_ctrl`

## Requirements
- R1: After the synchronous reset is released, `cpu_req` is high by the second rising edge with `vector` = `0xFFFE`, and `deep_sleep` is low.
- R2: While `cpu_req` is high, `vector` equals `0xFFC0` plus twice the selected slot number (slot 25 gives `0xFFF2`, slot 2 gives `0xFFC4`).
- R3: When several slots are eligible at the same time, the highest-numbered slot is served first, followed by the rest in descending order.
- R4: A slot other than 30 and 31 is never selected while `gie` is low, even when it is pending and enabled.
- R5: Slot 30 is selected while `gie` is low if `irq_en[30]` is high, and is not selected while `irq_en[30]` is low.
- R6: While `cpu_req` is high and `ack` is low, `vector` holds its value, even if a higher-priority request arrives.
- R7: `ack` (given only while `cpu_req` is high) drops `cpu_req` on the next edge. For a single-source slot it also clears that slot's pending state, so the slot is not requested again.
- R8: Acknowledging a shared slot (default shared set: 30, 24, 20, 19, 18) leaves its request untouched. If its level input is still high, it is requested again right away.
- R9: A pulse on any bit of `rst_cause` makes the reset slot pending, and it is selected regardless of `gie` and `irq_en`.
- R10: A fetch with `fetch_en` high raises a reset cause when the address is in one of these ranges: 0x0000–0x01FF, 0x0280–0x0FFF, or 0x1100–0xF7FF. A fetch at any other address does not raise one.
- R11: Acknowledging the reset vector with `ack_word` = `0xFFFF` sets `deep_sleep` on the next edge, and any other word leaves it low. A later reset cause clears it.
- R12: A single-source pulse that arrives while its enable is low stays pending and is requested once the enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; counts as the power-up cause |
| irq_in | input | 31 | Slot 0–30 requests: one-cycle pulses for single-source slots, levels for shared slots |
| irq_en | input | 31 | Per-slot enables for slots 0–30 |
| gie | input | 1 | Global enable for slots not exempt from it |
| rst_cause | input | 5 | Reset cause pulses: pin, watchdog expiry, flash key error, PC out of range, spare |
| fetch_en | input | 1 | Instruction fetch in progress |
| fetch_addr | input | 16 | Address of that fetch |
| ack | input | 1 | CPU takes the presented vector |
| ack_word | input | 16 | Word the CPU read from the vector, used for the reset vector |
| cpu_req | output | 1 | Request to the CPU |
| vector | output | 16 | Selected vector address |
| deep_sleep | output | 1 | Reset vector was blank; enter the deepest sleep mode |

## Verification
The assertions rely on two promises from the CPU. First, `ack` is asserted only while `cpu_req` is high. Second, `ack_word` carries the fetched vector word in the same cycle as that `ack`. They also assume that every single-source request is a one-cycle pulse. The directed tasks keep to all of this. Each task waits for `cpu_req` before it pulses `ack`, and pulses `ack` for exactly one cycle. Every event input is driven high for one cycle on a falling edge, and only the shared slots are held as levels.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NUM_SLOTS  = 32;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int SRC_N      = NUM_SLOTS - 1;
    localparam int RST_SLOT   = NUM_SLOTS - 1;
    localparam int NUM_CAUSES = 5;
    localparam int ADDR_W     = 16;

    localparam logic [ADDR_W-1:0] VEC_BASE   = 16'hFFC0;
    localparam logic [ADDR_W-1:0] BLANK_WORD = 16'hFFFF;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  valid;
        slot_t slot;
    } sel_t;

    // word-aligned vector address for a slot
    function automatic logic [ADDR_W-1:0] vec_of(slot_t s);
        return VEC_BASE | {{(ADDR_W-SLOT_W-1){1'b0}}, s, 1'b0};
    endfunction

endpackage

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard
    import ivc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PERIPH_END = 16'h01FF,
    parameter logic [ADDR_W-1:0] RAM_END    = 16'h027F,
    parameter logic [ADDR_W-1:0] INFO_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] INFO_END   = 16'h10FF,
    parameter logic [ADDR_W-1:0] CODE_BASE  = 16'hF800
) (
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              bad
);

    logic in_periph;
    logic in_gap_low;
    logic in_gap_high;

    always_comb begin
        in_periph   = (fetch_addr <= PERIPH_END);
        in_gap_low  = (fetch_addr > RAM_END)  && (fetch_addr < INFO_BASE);
        in_gap_high = (fetch_addr > INFO_END) && (fetch_addr < CODE_BASE);
        bad         = fetch_en && (in_periph || in_gap_low || in_gap_high);
    end

endmodule

// File: rtl/ivc_pending.sv
module ivc_pending
    import ivc_pkg::*;
#(
    parameter int                N      = SRC_N,
    parameter logic [N-1:0]      SHARED = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         take,
    input  slot_t        take_slot,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        if (SHARED[g]) begin : g_level
            // peripheral keeps its own flag; pass the level through
            assign pend[g] = evt[g];
        end else begin : g_latch
            logic hit;
            assign hit = take && (take_slot == slot_t'(g));
            always_ff @(posedge clk) begin
                if (rst)
                    pend[g] <= 1'b0;
                else if (evt[g])
                    pend[g] <= 1'b1;   // a new event beats a same-cycle clear
                else if (hit)
                    pend[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic [N-1:0] elig,
    output sel_t         win
);

    // ascending scan: the last hit, i.e. the highest slot, is kept
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                win.valid = 1'b1;
                win.slot  = slot_t'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_vector_ctrl.sv
module ivc_vector_ctrl
    import ivc_pkg::*;
#(
    parameter logic [SRC_N-1:0]  SHARED_MASK     = 31'h411C_0000,
    parameter logic [SRC_N-1:0]  GIE_EXEMPT_MASK = 31'h4000_0000,
    parameter logic [ADDR_W-1:0] PERIPH_END      = 16'h01FF,
    parameter logic [ADDR_W-1:0] RAM_END         = 16'h027F,
    parameter logic [ADDR_W-1:0] INFO_BASE       = 16'h1000,
    parameter logic [ADDR_W-1:0] INFO_END        = 16'h10FF,
    parameter logic [ADDR_W-1:0] CODE_BASE       = 16'hF800
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SRC_N-1:0]      irq_in,
    input  logic [SRC_N-1:0]      irq_en,
    input  logic                  gie,
    input  logic [NUM_CAUSES-1:0] rst_cause,
    input  logic                  fetch_en,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  ack,
    input  logic [ADDR_W-1:0]     ack_word,
    output logic                  cpu_req,
    output logic [ADDR_W-1:0]     vector,
    output logic                  deep_sleep
);

    logic                 fetch_bad;
    logic                 rst_hit;
    logic                 rst_pend;
    logic                 take;
    logic                 take_rst;
    logic [SRC_N-1:0]     pend;
    logic [NUM_SLOTS-1:0] elig;
    sel_t                 winner;
    sel_t                 held;

    ivc_fetch_guard #(
        .PERIPH_END (PERIPH_END),
        .RAM_END    (RAM_END),
        .INFO_BASE  (INFO_BASE),
        .INFO_END   (INFO_END),
        .CODE_BASE  (CODE_BASE)
    ) u_guard (
        .fetch_en   (fetch_en),
        .fetch_addr (fetch_addr),
        .bad        (fetch_bad)
    );

    assign take     = ack && held.valid;
    assign take_rst = take && (held.slot == slot_t'(RST_SLOT));
    assign rst_hit  = (|rst_cause) || fetch_bad;

    ivc_pending #(
        .N      (SRC_N),
        .SHARED (SHARED_MASK)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .evt       (irq_in),
        .take      (take),
        .take_slot (held.slot),
        .pend      (pend)
    );

    // reset slot: power-up sets it, any later cause sets it again
    always_ff @(posedge clk) begin
        if (rst)
            rst_pend <= 1'b1;
        else if (rst_hit)
            rst_pend <= 1'b1;
        else if (take_rst)
            rst_pend <= 1'b0;
    end

    assign elig = {rst_pend, pend & irq_en & ({SRC_N{gie}} | GIE_EXEMPT_MASK)};

    ivc_arbiter #(
        .N (NUM_SLOTS)
    ) u_arb (
        .elig (elig),
        .win  (winner)
    );

    // selection is frozen from request until acknowledge
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (held.valid) begin
            if (ack)
                held.valid <= 1'b0;
        end else
            held <= winner;
    end

    always_ff @(posedge clk) begin
        if (rst)
            deep_sleep <= 1'b0;
        else if (rst_hit)
            deep_sleep <= 1'b0;
        else if (take_rst && (ack_word == BLANK_WORD))
            deep_sleep <= 1'b1;
    end

    assign cpu_req = held.valid;
    assign vector  = vec_of(held.slot);

endmodule

// File: rtl/ivc_vector_ctrl_chk.sv
module ivc_vector_ctrl_chk
    import ivc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  ack,
    input logic [ADDR_W-1:0]     ack_word,
    input logic [NUM_CAUSES-1:0] rst_cause,
    input logic                  cpu_req,
    input logic [ADDR_W-1:0]     vector,
    input logic                  deep_sleep,
    input logic                  rst_pend,
    input logic                  fetch_bad
);

    assert_vec_window_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (vector[15:6] == 10'h3FF) && !vector[0]);

    assert_vec_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !ack) |=> (cpu_req && $stable(vector)));

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && cpu_req) |=> !cpu_req);

    assert_rst_first_R9: assert property (@(posedge clk) disable iff (rst)
        (!cpu_req && rst_pend) |=> (cpu_req && vector == 16'hFFFE));

    assert_blank_sleep_R11: assert property (@(posedge clk) disable iff (rst)
        (ack && cpu_req && vector == 16'hFFFE && ack_word == 16'hFFFF
         && rst_cause == '0 && !fetch_bad) |=> deep_sleep);

    assert_cause_wakes_R11: assert property (@(posedge clk) disable iff (rst)
        (rst_cause != '0) |=> !deep_sleep);

endmodule

bind ivc_vector_ctrl ivc_vector_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .ack_word   (ack_word),
    .rst_cause  (rst_cause),
    .cpu_req    (cpu_req),
    .vector     (vector),
    .deep_sleep (deep_sleep),
    .rst_pend   (rst_pend),
    .fetch_bad  (fetch_bad)
);

// File: tb/ivc_vector_ctrl_test.sv
module ivc_vector_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] irq_in = '0;
    logic [30:0] irq_en = '0;
    logic        gie = 1'b0;
    logic [4:0]  rst_cause = '0;
    logic        fetch_en = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        ack = 1'b0;
    logic [15:0] ack_word = '0;
    logic        cpu_req;
    logic [15:0] vector;
    logic        deep_sleep;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ivc_vector_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .irq_en     (irq_en),
        .gie        (gie),
        .rst_cause  (rst_cause),
        .fetch_en   (fetch_en),
        .fetch_addr (fetch_addr),
        .ack        (ack),
        .ack_word   (ack_word),
        .cpu_req    (cpu_req),
        .vector     (vector),
        .deep_sleep (deep_sleep)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(int s);
        @(negedge clk) irq_in[s] = 1'b1;
        @(negedge clk) irq_in[s] = 1'b0;
    endtask

    task automatic pulse_cause(int c);
        @(negedge clk) rst_cause[c] = 1'b1;
        @(negedge clk) rst_cause[c] = 1'b0;
    endtask

    task automatic take(logic [15:0] w);
        @(negedge clk) begin ack = 1'b1; ack_word = w; end
        @(negedge clk) begin ack = 1'b0; ack_word = '0; end
    endtask

    task automatic expect_vec(string tag, logic [15:0] v);
        check({tag, " req"}, {15'd0, cpu_req}, 16'd1);
        check({tag, " vec"}, vector, v);
    endtask

    task automatic expect_idle(string tag);
        check({tag, " idle"}, {15'd0, cpu_req}, 16'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        expect_vec("R1 power-up", 16'hFFFE);
        check("R1 deep_sleep", {15'd0, deep_sleep}, 16'd0);
        take(16'hF800);
        expect_idle("R7 after reset ack");
        check("R11 nonblank word", {15'd0, deep_sleep}, 16'd0);
    endtask

    task automatic t_single();
        irq_en = '1; gie = 1'b1;
        pulse_irq(25);
        wait_n(2);
        expect_vec("R2 slot25", 16'hFFF2);
        take(16'h0);
        expect_idle("R7 drop");
        wait_n(3);
        expect_idle("R7 cleared");
    endtask

    task automatic t_priority();
        gie = 1'b0;
        pulse_irq(26); pulse_irq(21); pulse_irq(2);
        wait_n(3);
        expect_idle("R4 gie low");
        gie = 1'b1;
        wait_n(2);
        expect_vec("R3 first", 16'hFFF4);
        take(16'h0);
        wait_n(1);
        expect_vec("R3 second", 16'hFFEA);
        take(16'h0);
        wait_n(1);
        expect_vec("R2 slot2", 16'hFFC4);
        take(16'h0);
        wait_n(3);
        expect_idle("R3 drained");
    endtask

    task automatic t_nmi();
        gie = 1'b0;
        irq_en[30] = 1'b0;
        irq_in[30] = 1'b1;
        wait_n(3);
        expect_idle("R5 own enable low");
        irq_en[30] = 1'b1;
        wait_n(2);
        expect_vec("R5 gie ignored", 16'hFFFC);
        take(16'h0);
        expect_idle("R7 nmi ack");
        wait_n(1);
        expect_vec("R8 shared again", 16'hFFFC);
        irq_in[30] = 1'b0;
        take(16'h0);
        wait_n(3);
        expect_idle("R8 level gone");
        gie = 1'b1;
    endtask

    task automatic t_hold();
        pulse_irq(5);
        wait_n(2);
        expect_vec("R6 low first", 16'hFFCA);
        pulse_irq(26);
        wait_n(3);
        expect_vec("R6 held", 16'hFFCA);
        take(16'h0);
        wait_n(1);
        expect_vec("R3 late high", 16'hFFF4);
        take(16'h0);
        wait_n(2);
        expect_idle("R6 drained");
    endtask

    task automatic t_retain();
        irq_en[10] = 1'b0;
        pulse_irq(10);
        wait_n(3);
        expect_idle("R12 disabled");
        irq_en[10] = 1'b1;
        wait_n(2);
        expect_vec("R12 enabled later", 16'hFFD4);
        take(16'h0);
        wait_n(2);
        expect_idle("R12 drained");
    endtask

    task automatic t_causes();
        gie = 1'b0; irq_en = '0;
        for (int c = 0; c < 5; c++) begin
            pulse_cause(c);
            wait_n(2);
            expect_vec($sformatf("R9 cause%0d", c), 16'hFFFE);
            take(16'hF800);
            wait_n(2);
            expect_idle("R9 drained");
        end
    endtask

    task automatic fetch_at(logic [15:0] a, bit bad);
        @(negedge clk) begin fetch_en = 1'b1; fetch_addr = a; end
        @(negedge clk) begin fetch_en = 1'b0; fetch_addr = '0; end
        wait_n(2);
        if (bad) begin
            expect_vec($sformatf("R10 bad %h", a), 16'hFFFE);
            take(16'hF800);
            wait_n(2);
        end else
            expect_idle($sformatf("R10 legal %h", a));
    endtask

    task automatic t_fetch();
        fetch_at(16'h0100, 1'b1);
        fetch_at(16'h01FF, 1'b1);
        fetch_at(16'h0200, 1'b0);
        fetch_at(16'h027F, 1'b0);
        fetch_at(16'h0280, 1'b1);
        fetch_at(16'h0FFF, 1'b1);
        fetch_at(16'h1000, 1'b0);
        fetch_at(16'h10FF, 1'b0);
        fetch_at(16'h1100, 1'b1);
        fetch_at(16'hF7FF, 1'b1);
        fetch_at(16'hF800, 1'b0);
        fetch_at(16'hFFFE, 1'b0);
    endtask

    task automatic t_sleep();
        pulse_cause(1);
        wait_n(2);
        expect_vec("R11 cause", 16'hFFFE);
        take(16'hFFFF);
        check("R11 blank sets", {15'd0, deep_sleep}, 16'd1);
        wait_n(3);
        check("R11 sticky", {15'd0, deep_sleep}, 16'd1);
        @(negedge clk) rst_cause[0] = 1'b1;
        @(negedge clk) rst_cause[0] = 1'b0;
        check("R11 cause clears", {15'd0, deep_sleep}, 16'd0);
        wait_n(1);
        expect_vec("R9 after sleep", 16'hFFFE);
        take(16'hF800);
        wait_n(2);
        check("R11 stays low", {15'd0, deep_sleep}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_nmi();
        t_hold();
        t_retain();
        t_causes();
        t_fetch();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule